// File: doc/BRIEF.md
# Flash Embedded-Operation Status Reporter

This block is the read-side status logic of a multi-bank NOR flash. While a program or erase algorithm runs in the background, a read strobe, one per chip-enable low pulse, returns either a status word or normal array data, depending on the bank and sector addressed. The embedded-algorithm controller supplies the busy indication, the operation type, the bank and sector under work, bit 7 of the byte being programmed, the erase-suspend state and a time-limit event. The block forms the 16-bit read word, keeps the two toggle flip-flops and a sticky time-limit flag, and drives an enable for the open-drain ready/busy pin.

A read that lands in the busy bank gets status bits. A read of any other bank gets the word from a combinational array port. While an erase is suspended, only the suspended sector reports status; every other sector returns array data. Each read result is registered and appears one clock after its strobe, together with a one-cycle valid pulse.

Top module: `flash_status_rpt`

## Requirements
- R1: After reset, `rd_valid`, `rd_data` and `rdy_oe` are all 0.
- R2: A read of a bank other than `op_bank`, or any read while `op_busy` is 0, returns `arr_rdata`. `arr_addr` is {`rd_bank`,`rd_sector`} and `arr_rd` is high for that strobe. Such reads do not advance either toggle bit.
- R3: A status read during a program returns bit 7 = NOT `prog_msb`. Bit 3 and bit 2 read 0.
- R4: A status read during an active erase returns bit 7 = 0 and bit 3 = 1.
- R5: Bit 6 reads 0 on the first status read after `op_start`, then inverts on each later status read while the operation is not suspended.
- R6: While an erase is suspended (`ers_susp`=1 and `op_erase`=1), a read of sector `ers_sector` in the busy bank returns bit 7 = 1, bit 3 = 0, and bit 6 held at its last value.
- R7: Bit 2 starts at 0 at `op_start` and inverts after each erase-mode status read of sector `ers_sector`, whether the erase is active or suspended. A status read of any other sector shows bit 2 unchanged and does not advance it.
- R8: While an erase is suspended, a read of a sector other than `ers_sector` in the busy bank returns array data.
- R9: Bit 5 of status reads is 1 from the cycle after a `tlim_hit` pulse until a `tlim_clr` pulse, and 0 otherwise. `tlim_clr` wins when both pulses arrive together.
- R10: In a status word, bits 15..8, bit 4, bit 1 and bit 0 read 0.
- R11: `rdy_oe` (ready pin driven low) equals `op_busy`. When it is 0 the pin is left high-impedance.
- R12: `rd_data` and a one-cycle `rd_valid` pulse appear one clock after the `rd_stb` cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_stb | input | 1 | One-cycle read event, one per chip-enable pulse |
| rd_bank | input | BANK_W | Bank of the read address |
| rd_sector | input | SEC_W | Sector of the read address, within its bank |
| op_busy | input | 1 | Embedded operation in progress |
| op_start | input | 1 | One-cycle pulse at the start of an operation |
| op_erase | input | 1 | 1 = erase, 0 = program |
| op_bank | input | BANK_W | Bank running the embedded operation |
| ers_sector | input | SEC_W | Sector being erased or erase-suspended |
| ers_susp | input | 1 | Erase is suspended |
| prog_msb | input | 1 | Bit 7 of the byte being programmed |
| tlim_hit | input | 1 | Operation exceeded its time limit (pulse) |
| tlim_clr | input | 1 | Reset command clears the time-limit flag (pulse) |
| arr_rdata | input | 16 | Array word for `arr_addr`, same cycle |
| arr_addr | output | BANK_W+SEC_W | Array read address |
| arr_rd | output | 1 | Array read enable |
| rd_data | output | 16 | Registered read word |
| rd_valid | output | 1 | `rd_data` is new this cycle |
| rdy_oe | output | 1 | Drive the ready pin low |

## Verification
Every read result is due exactly one clock after its strobe. The driver applies the strobe on a falling edge and pushes the expected word into a queue. The monitor pops that word on the next falling edge, when `rd_valid` must be high. A valid pulse with an empty queue counts as a miscompare. `rdy_oe` and `arr_rd` depend on the inputs without a register, so they are checked one nanosecond after the driver changes them. The expected toggle-bit values come from the bench's own counters, which restart at each `op_start`. The time-limit flag takes one clock to set or clear, so the bench pulses `tlim_hit` and `tlim_clr` on a cycle of their own before the next read.

// File: rtl/flash_status_pkg.sv
package flash_status_pkg;

  localparam int DATA_W = 16;

  typedef enum logic [1:0] {
    MODE_PROG   = 2'd0,
    MODE_ERASE  = 2'd1,
    MODE_SUSP   = 2'd2
  } st_mode_e;

  localparam int TOG_SIX = 0;
  localparam int TOG_TWO = 1;
  localparam int NTOG    = 2;

  function automatic st_mode_e pick_mode(input logic erase, input logic susp);
    if (erase && susp) return MODE_SUSP;
    if (erase)         return MODE_ERASE;
    return MODE_PROG;
  endfunction

  // Builds a status word; undefined bit positions stay 0.
  function automatic logic [DATA_W-1:0] status_word(
      input st_mode_e mode,
      input logic     pmsb,
      input logic     tmo,
      input logic     t6,
      input logic     t2);
    logic [DATA_W-1:0] w;
    w    = '0;
    w[6] = t6;
    w[5] = tmo;
    unique case (mode)
      MODE_SUSP: begin
        w[7] = 1'b1;
        w[2] = t2;
      end
      MODE_ERASE: begin
        w[7] = 1'b0;
        w[3] = 1'b1;
        w[2] = t2;
      end
      default: begin
        w[7] = ~pmsb;
      end
    endcase
    return w;
  endfunction

endpackage

// File: rtl/fsr_tbit.sv
module fsr_tbit (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic adv,
  output logic q
);
  always_ff @(posedge clk) begin
    if (!rst_n)   q <= 1'b0;
    else if (clr) q <= 1'b0;
    else if (adv) q <= ~q;
  end
endmodule

// File: rtl/fsr_tmo.sv
module fsr_tmo (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic q
);
  always_ff @(posedge clk) begin
    if (!rst_n)   q <= 1'b0;
    else if (clr) q <= 1'b0;
    else if (set) q <= 1'b1;
  end
endmodule

// File: rtl/fsr_route.sv
module fsr_route #(
  parameter int BANK_W = 2,
  parameter int SEC_W  = 3
) (
  input  logic              op_busy,
  input  logic              op_erase,
  input  logic              ers_susp,
  input  logic [BANK_W-1:0] rd_bank,
  input  logic [SEC_W-1:0]  rd_sector,
  input  logic [BANK_W-1:0] op_bank,
  input  logic [SEC_W-1:0]  ers_sector,
  output logic              susp_eff,
  output logic              sec_hit,
  output logic              st_sel
);
  logic bank_hit;
  always_comb begin
    susp_eff = op_erase & ers_susp;
    bank_hit = op_busy & (rd_bank == op_bank);
    sec_hit  = (rd_sector == ers_sector);
    st_sel   = bank_hit & ~(susp_eff & ~sec_hit);
  end
endmodule

// File: rtl/flash_status_rpt.sv
module flash_status_rpt
  import flash_status_pkg::*;
#(
  parameter int BANK_W = 2,
  parameter int SEC_W  = 3
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    rd_stb,
  input  logic [BANK_W-1:0]       rd_bank,
  input  logic [SEC_W-1:0]        rd_sector,
  input  logic                    op_busy,
  input  logic                    op_start,
  input  logic                    op_erase,
  input  logic [BANK_W-1:0]       op_bank,
  input  logic [SEC_W-1:0]        ers_sector,
  input  logic                    ers_susp,
  input  logic                    prog_msb,
  input  logic                    tlim_hit,
  input  logic                    tlim_clr,
  input  logic [DATA_W-1:0]       arr_rdata,
  output logic [BANK_W+SEC_W-1:0] arr_addr,
  output logic                    arr_rd,
  output logic [DATA_W-1:0]       rd_data,
  output logic                    rd_valid,
  output logic                    rdy_oe
);
  localparam int ADDR_W = BANK_W + SEC_W;

  logic              susp_eff, sec_hit, st_sel, st_hit;
  logic              tmo_q, rd_is_stat;
  logic [NTOG-1:0]   tog_q, tog_adv;
  logic [DATA_W-1:0] st_word;
  st_mode_e          mode;

  fsr_route #(.BANK_W(BANK_W), .SEC_W(SEC_W)) u_route (
    .op_busy(op_busy), .op_erase(op_erase), .ers_susp(ers_susp),
    .rd_bank(rd_bank), .rd_sector(rd_sector), .op_bank(op_bank),
    .ers_sector(ers_sector), .susp_eff(susp_eff), .sec_hit(sec_hit),
    .st_sel(st_sel)
  );

  assign st_hit = rd_stb & st_sel;
  assign mode   = pick_mode(op_erase, susp_eff);

  // Advance enables: bit 6 on any unsuspended status read,
  // bit 2 on an erase-mode status read of the erase sector.
  assign tog_adv[TOG_SIX] = st_hit & ~susp_eff;
  assign tog_adv[TOG_TWO] = st_hit & op_erase & sec_hit;

  for (genvar g = 0; g < NTOG; g++) begin : g_tog
    fsr_tbit u_tbit (
      .clk(clk), .rst_n(rst_n), .clr(op_start),
      .adv(tog_adv[g]), .q(tog_q[g])
    );
  end

  fsr_tmo u_tmo (
    .clk(clk), .rst_n(rst_n), .set(tlim_hit), .clr(tlim_clr), .q(tmo_q)
  );

  assign st_word  = status_word(mode, prog_msb, tmo_q,
                                tog_q[TOG_SIX], tog_q[TOG_TWO]);
  assign arr_addr = ADDR_W'({rd_bank, rd_sector});
  assign arr_rd   = rd_stb & ~st_sel;
  assign rdy_oe   = op_busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_data    <= '0;
      rd_valid   <= 1'b0;
      rd_is_stat <= 1'b0;
    end else begin
      rd_valid   <= rd_stb;
      rd_is_stat <= st_hit;
      if (rd_stb) rd_data <= st_sel ? st_word : arr_rdata;
    end
  end
endmodule

// File: rtl/flash_status_rpt_chk.sv
module flash_status_rpt_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        op_start,
  input logic        st_hit,
  input logic        susp_eff,
  input logic        t6_q,
  input logic        t2_q,
  input logic        adv2,
  input logic        tmo_q,
  input logic        tlim_clr,
  input logic        rd_stb,
  input logic        rd_valid,
  input logic        rd_is_stat,
  input logic [15:0] rd_data
);
  AST_T6_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
    (st_hit && !susp_eff && !op_start) |=> (t6_q != $past(t6_q))); // R5
  AST_T6_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    (st_hit && susp_eff && !op_start) |=> $stable(t6_q)); // R6
  AST_START_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    op_start |=> (!t6_q && !t2_q)); // R5
  AST_T2_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!adv2 && !op_start) |=> $stable(t2_q)); // R7
  AST_TMO_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (tmo_q && !tlim_clr) |=> tmo_q); // R9
  AST_VALID_LAT: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stb |=> rd_valid); // R12
  AST_STAT_SPARE: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && rd_is_stat) |->
      (rd_data[15:8] == 8'h00 && !rd_data[4] && rd_data[1:0] == 2'b00)); // R10
endmodule

bind flash_status_rpt flash_status_rpt_chk u_chk (
  .clk(clk), .rst_n(rst_n), .op_start(op_start), .st_hit(st_hit),
  .susp_eff(susp_eff), .t6_q(tog_q[0]), .t2_q(tog_q[1]),
  .adv2(tog_adv[1]), .tmo_q(tmo_q), .tlim_clr(tlim_clr),
  .rd_stb(rd_stb), .rd_valid(rd_valid), .rd_is_stat(rd_is_stat),
  .rd_data(rd_data)
);

// File: tb/flash_status_rpt_bench.sv
`timescale 1ns/1ps
module flash_status_rpt_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rd_stb = 0, op_busy = 0, op_start = 0, op_erase = 0;
  logic ers_susp = 0, prog_msb = 0, tlim_hit = 0, tlim_clr = 0;
  logic [1:0] rd_bank = 0, op_bank = 0;
  logic [2:0] rd_sector = 0, ers_sector = 0;
  logic [15:0] arr_rdata, rd_data;
  logic [4:0]  arr_addr;
  logic arr_rd, rd_valid, rdy_oe;

  always #2.5 clk = ~clk;

  // Array model: upper byte marks array data, low bits echo the address.
  assign arr_rdata = {8'hA5, 3'b000, arr_addr};

  flash_status_rpt u_flash_status_rpt (.*);

  int n_vec = 0, n_bad = 0;
  logic [15:0] exp_q[$];
  string       tag_q[$];
  logic b_busy = 0, b_erase = 0, b_susp = 0, b_pmsb = 0, b_tmo = 0;
  logic [1:0] b_bank = 0;
  logic [2:0] b_sec = 0;
  logic m6 = 0, m2 = 0;
  bit done = 0;

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  // Driver: computes the expected word from the requirements, queues it, strobes.
  task automatic do_read(input logic [1:0] b, input logic [2:0] s, input string tag);
    logic susp, stat;
    logic [15:0] e;
    susp = b_susp & b_erase;
    stat = b_busy && (b == b_bank) && !(susp && (s != b_sec));
    e = 16'h0000;
    if (!stat) e = {8'hA5, 3'b000, b, s};
    else begin
      e[6] = m6;
      e[5] = b_tmo;
      if (susp) begin e[7] = 1'b1; e[2] = m2; end
      else if (b_erase) begin e[3] = 1'b1; e[2] = m2; end
      else e[7] = ~b_pmsb;
    end
    if (stat && !susp) m6 = ~m6;
    if (stat && b_erase && (s == b_sec)) m2 = ~m2;
    exp_q.push_back(e);
    tag_q.push_back(tag);
    rd_stb = 1; rd_bank = b; rd_sector = s;
    #1 check({tag, " arr_rd R2"}, 16'(arr_rd), 16'(!stat));
    @(negedge clk);
    rd_stb = 0;
  endtask

  task automatic start_op(input logic [1:0] b, input logic er, input logic [2:0] s, input logic pm);
    op_busy = 1; op_start = 1; op_bank = b; op_erase = er; ers_sector = s; prog_msb = pm;
    b_busy = 1; b_bank = b; b_erase = er; b_sec = s; b_pmsb = pm; m6 = 0; m2 = 0;
    #1 check("R11 rdy_oe busy", 16'(rdy_oe), 16'd1);
    @(negedge clk);
    op_start = 0;
  endtask

  task automatic end_op();
    op_busy = 0; b_busy = 0; ers_susp = 0; b_susp = 0;
    #1 check("R11 rdy_oe idle", 16'(rdy_oe), 16'd0);
    @(negedge clk);
  endtask

  // Monitor: each valid pulse pops the next expected word.
  always @(negedge clk) begin
    if (rst_n && rd_valid) begin
      if (exp_q.size() == 0) begin
        n_vec++; n_bad++;
        $display("FAIL R12: valid with nothing pending, got %h expected none", rd_data);
      end else begin
        string t;
        logic [15:0] e;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(t, rd_data, e);
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 rd_valid", 16'(rd_valid), 16'd0);
    check("R1 rd_data", rd_data, 16'h0000);
    check("R1 rdy_oe", 16'(rdy_oe), 16'd0);
    rst_n = 1;
    @(negedge clk);
    do_read(2'd1, 3'd2, "R2 idle read");
    // Program, bit 7 = 1.
    start_op(2'd1, 1'b0, 3'd0, 1'b1);
    do_read(2'd1, 3'd4, "R3 R5 prog read 1");
    do_read(2'd1, 3'd4, "R5 prog read 2");
    do_read(2'd2, 3'd1, "R2 other bank");
    do_read(2'd1, 3'd0, "R5 prog read 3");
    prog_msb = 0; b_pmsb = 0;
    do_read(2'd1, 3'd0, "R3 prog msb 0");
    tlim_hit = 1; @(negedge clk); tlim_hit = 0; b_tmo = 1;
    do_read(2'd1, 3'd3, "R9 timeout set");
    do_read(2'd1, 3'd3, "R9 timeout held");
    end_op();
    do_read(2'd1, 3'd3, "R2 after op");
    tlim_hit = 1; tlim_clr = 1; @(negedge clk); tlim_hit = 0; tlim_clr = 0; b_tmo = 0;
    // Erase bank 0 sector 3.
    start_op(2'd0, 1'b1, 3'd3, 1'b0);
    do_read(2'd0, 3'd3, "R4 R7 erase sector");
    do_read(2'd0, 3'd3, "R7 erase sector again");
    do_read(2'd0, 3'd1, "R7 other sector held");
    do_read(2'd0, 3'd3, "R7 R10 erase sector 3rd");
    ers_susp = 1; b_susp = 1;
    do_read(2'd0, 3'd3, "R6 suspended sector");
    do_read(2'd0, 3'd3, "R6 R7 suspended again");
    do_read(2'd0, 3'd5, "R8 non-suspended sector");
    do_read(2'd3, 3'd3, "R2 other bank in suspend");
    ers_susp = 0; b_susp = 0;
    do_read(2'd0, 3'd3, "R5 resumed");
    // A new operation restarts the toggle bits.
    start_op(2'd0, 1'b1, 3'd6, 1'b0);
    do_read(2'd0, 3'd6, "R5 R7 restart");
    do_read(2'd0, 3'd6, "R5 R7 restart 2");
    end_op();
    repeat (3) @(negedge clk);
    check("R12 queue drained", 16'(exp_q.size()), 16'd0);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    #50000;
    if (!done) begin
      n_vec++; n_bad++;
      $display("FAIL watchdog: got hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule